// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Master

This block is a bus master that carries out single-word reads and writes against a slave that answers through an unclocked request/acknowledge handshake. The master logic itself runs on a local clock. The slave's acknowledge line is therefore brought in through a two-stage synchronizer, and every state decision uses only the synchronized copy.

A transfer starts when the local side presents a command while the master is idle. The master then puts the address, the transfer direction and, for a write, the data onto the bus. It holds them for a fixed decode interval so that slaves can recognise their address, and only then raises request. It waits for acknowledge, drops request, and waits for acknowledge to fall again before it reports completion and accepts the next address. Read data is sampled on the clock edge at which request is withdrawn. The write-data drivers stay enabled until acknowledge has returned low.

A watchdog limits how long the master waits in either half of the handshake. If the slave stops answering, the master abandons the transfer, releases the bus and reports the transfer as failed.

Top module: `hsk4_bus_master`

## Requirements
- R1: During and right after reset, bus_req, bus_wdata_oe and rsp_valid are 0 and cmd_ready is 1.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. From the next cycle, bus_addr, bus_dir and bus_wdata show that command, with bus_dir=1 meaning write. bus_wdata_oe is 1 for writes only, and cmd_ready is 0 until the transfer ends.
- R3: bus_req rises exactly DECODE_CYC clock cycles after the cycle in which the new address first appears. DECODE_CYC defaults to 2.
- R4: bus_ack passes through two synchronizer flops. bus_req falls on the third rising clock edge after bus_ack rises, and falls only after acknowledge was seen or on a watchdog abort.
- R5: For a read, rsp_rdata holds the bus_rdata value present at the edge where bus_req falls. Later changes on bus_rdata do not alter it.
- R6: rsp_valid is a one-cycle pulse on the third rising edge after bus_ack falls. cmd_ready returns to 1 in the same cycle, and bus_addr does not change before then.
- R7: During a write, bus_wdata_oe stays 1 and bus_wdata stays unchanged until acknowledge has been seen low. bus_wdata_oe is 0 whenever the master is idle.
- R8: cmd_valid asserted while a transfer is in progress is ignored: the bus fields do not change and no extra transfer is made.
- R9: If acknowledge is not seen within WDOG_CYC cycles (default 64) of bus_req rising, bus_req is held high for exactly WDOG_CYC cycles. The transfer then ends with rsp_valid=1, rsp_err=1 and bus_wdata_oe=0.
- R10: If acknowledge stays high for WDOG_CYC cycles after bus_req falls, the transfer ends with rsp_valid=1 and rsp_err=1 exactly WDOG_CYC cycles after bus_req fell. The master then accepts new commands.
- R11: A transfer that completes the full handshake reports rsp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Target address |
| cmd_wdata | input | DW | Write data |
| cmd_ready | output | 1 | Master idle, command can be taken |
| bus_addr | output | AW | Address lines |
| bus_dir | output | 1 | Direction line, 1 = write |
| bus_wdata | output | DW | Write data lines |
| bus_wdata_oe | output | 1 | Write data driver enable |
| bus_req | output | 1 | Request line |
| bus_ack | input | 1 | Acknowledge line from slave, asynchronous |
| bus_rdata | input | DW | Read data lines from slave |
| rsp_valid | output | 1 | Transfer finished (one-cycle pulse) |
| rsp_err | output | 1 | Transfer aborted by watchdog, valid with rsp_valid |
| rsp_rdata | output | DW | Captured read data |

## Verification
The bench times each handshake edge against the cycle counts in the requirements: the decode delay, the three-edge synchronizer latency in both directions, and the completion pulse. A master that skipped the synchronizer or miscounted the decode interval would be off by a cycle and would be reported. The slave model puts garbage on the read lines as soon as it sees request fall, so a master that sampled read data late would return garbage. The model also checks the write drivers while it drops acknowledge, which catches a master that releases them too early. Separate tests cover a slave that never answers, a slave whose acknowledge sticks high, and commands issued while the master is busy. Each of these must end in the exact watchdog count, a clean bus, and either one response or no extra response.

// File: rtl/hsk4_pkg.sv
// Package: shared state encoding for the four-phase handshake master.
// Assumes nothing beyond standard SystemVerilog enum support.
package hsk4_pkg;

    // Handshake sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // bus released, waiting for a command
        PH_SETUP = 2'd1,   // address valid, decode interval running
        PH_REQ   = 2'd2,   // request high, waiting for acknowledge
        PH_REL   = 2'd3    // request low, waiting for acknowledge to fall
    } hsk_phase_e;

endpackage

// File: rtl/hsk4_ack_sync.sv
// Module: multi-flop synchronizer for the slave acknowledge line.
// Assumes the input is asynchronous to clk. The output is delayed by STAGES
// rising edges. Synchronous active-low reset clears every stage.
module hsk4_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the asynchronous line
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/hsk4_phase_timer.sv
// Module: cycle counter shared by the decode interval and the watchdog.
// Assumes the controller clears it on every phase change. It saturates
// at its top value and never wraps.
module hsk4_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] TOP = '1;

    // Count cycles within the current phase
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

endmodule

// File: rtl/hsk4_bus_datapath.sv
// Module: bus-side registers: address, direction, write data, driver enable
// and read-data capture. Assumes load only when idle, and capture only on the
// edge where request is withdrawn.
module hsk4_bus_datapath #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          ld_write,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_wdata,
    input  logic          capture,
    input  logic          release_drv,
    input  logic          busy,
    input  logic [DW-1:0] rdata_in,
    output logic [AW-1:0] addr_q,
    output logic          dir_q,
    output logic [DW-1:0] wdata_q,
    output logic          oe_q,
    output logic [DW-1:0] rdata_q
);

    // Present a new command on the bus lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            dir_q   <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= ld_addr;
            dir_q   <= ld_write;
            wdata_q <= ld_wdata;
        end
    end

    // Write driver enable: on at load for writes, off when the transfer ends
    always_ff @(posedge clk) begin
        if (!rst_n)           oe_q <= 1'b0;
        else if (load)        oe_q <= ld_write;
        else if (release_drv) oe_q <= 1'b0;
    end

    // Sample read data as request is withdrawn
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (capture && !dir_q) rdata_q <= rdata_in;
    end

    // R2/R6: the address is held for the whole transfer
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));

    // R7: write drivers are on for the whole write and off when idle
    assert_wdata_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dir_q) |-> oe_q);

    assert_idle_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !oe_q);

    // R7: write data does not move while the drivers are on
    assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && $past(oe_q)) |-> $stable(wdata_q));

endmodule

// File: rtl/hsk4_ctrl.sv
// Module: four-phase sequencer. Runs decode delay, request, release and
// completion, with a watchdog on both acknowledge waits. Assumes ack_s is
// already synchronized. DECODE_CYC and WDOG_CYC must be at least 1.
module hsk4_ctrl
    import hsk4_pkg::*;
#(
    parameter int DECODE_CYC = 2,
    parameter int WDOG_CYC   = 64,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ack_s,
    input  logic [CW-1:0] count,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          load,
    output logic          capture,
    output logic          release_drv,
    output logic          idle,
    output logic          req_q,
    output logic          rsp_valid_q,
    output logic          rsp_err_q
);

    localparam logic [CW-1:0] DEC_LAST = CW'(DECODE_CYC - 1);
    localparam logic [CW-1:0] WD_LAST  = CW'(WDOG_CYC - 1);

    hsk_phase_e phase_q, phase_d;
    logic       finish_ok, finish_err;

    // Next phase and per-cycle strobes
    always_comb begin
        phase_d     = phase_q;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        load        = 1'b0;
        capture     = 1'b0;
        finish_ok   = 1'b0;
        finish_err  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    cnt_clr = 1'b1;
                    phase_d = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (count == DEC_LAST) begin
                    cnt_clr = 1'b1;
                    phase_d = PH_REQ;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_REQ: begin
                if (ack_s) begin
                    capture = 1'b1;
                    cnt_clr = 1'b1;
                    phase_d = PH_REL;
                end else if (count == WD_LAST) begin
                    finish_err = 1'b1;
                    phase_d    = PH_IDLE;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_REL: begin
                if (!ack_s) begin
                    finish_ok = 1'b1;
                    phase_d   = PH_IDLE;
                end else if (count == WD_LAST) begin
                    finish_err = 1'b1;
                    phase_d    = PH_IDLE;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign release_drv = finish_ok || finish_err;
    assign idle        = (phase_q == PH_IDLE);

    // Phase register and registered request line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            req_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            req_q   <= (phase_d == PH_REQ);
        end
    end

    // Completion response pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= release_drv;
            rsp_err_q   <= finish_err;
        end
    end

    // R1: no request while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !req_q);

    // R4: request is withdrawn only after acknowledge or a watchdog abort
    assert_req_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_q) && !rsp_valid_q) |-> $past(ack_s));

    // R6: the response is a single-cycle pulse
    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_q |=> !rsp_valid_q);

    // R9/R10: the watchdog count never passes its limit while waiting
    assert_wdog_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_REQ || phase_q == PH_REL) |-> (count <= WD_LAST));

    // R11: an error is only flagged together with a response
    assert_err_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_q |-> rsp_valid_q);

endmodule

// File: rtl/hsk4_bus_master.sv
// Module: top of the four-phase request/acknowledge bus master.
// Assumes the slave follows return-to-zero signalling and bus_rdata is
// stable while acknowledge is high. Synchronous active-low reset.
module hsk4_bus_master #(
    parameter int AW         = 8,
    parameter int DW         = 16,
    parameter int DECODE_CYC = 2,
    parameter int WDOG_CYC   = 64,
    parameter int SYNC_STG   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          cmd_ready,
    output logic [AW-1:0] bus_addr,
    output logic          bus_dir,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    output logic          bus_req,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata
);

    localparam int CNT_MAX = (WDOG_CYC > DECODE_CYC) ? WDOG_CYC : DECODE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic          ack_s;
    logic [CW-1:0] count;
    logic          cnt_clr, cnt_inc, load, capture, release_drv, idle;

    hsk4_ack_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ack),
        .sync_out (ack_s)
    );

    hsk4_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    hsk4_ctrl #(
        .DECODE_CYC (DECODE_CYC),
        .WDOG_CYC   (WDOG_CYC),
        .CW         (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_valid),
        .ack_s       (ack_s),
        .count       (count),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .load        (load),
        .capture     (capture),
        .release_drv (release_drv),
        .idle        (idle),
        .req_q       (bus_req),
        .rsp_valid_q (rsp_valid),
        .rsp_err_q   (rsp_err)
    );

    hsk4_bus_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .ld_write    (cmd_write),
        .ld_addr     (cmd_addr),
        .ld_wdata    (cmd_wdata),
        .capture     (capture),
        .release_drv (release_drv),
        .busy        (!idle),
        .rdata_in    (bus_rdata),
        .addr_q      (bus_addr),
        .dir_q       (bus_dir),
        .wdata_q     (bus_wdata),
        .oe_q        (bus_wdata_oe),
        .rdata_q     (rsp_rdata)
    );

    assign cmd_ready = idle;

endmodule

// File: tb/hsk4_bus_master_tb.sv
// Bench: table-driven transfers against a behavioural four-phase slave,
// then directed tests for reset, busy commands and both watchdog paths.
module hsk4_bus_master_tb;

    localparam int AW = 8, DW = 16, DEC = 2, WD = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic cmd_ready, bus_dir, bus_wdata_oe, bus_req, rsp_valid, rsp_err;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, rsp_rdata;
    logic sl_ack = 1'b0;
    logic [DW-1:0] sl_rdata = '0;

    always #4 clk = ~clk;   // 125 MHz

    hsk4_bus_master #(.AW(AW), .DW(DW), .DECODE_CYC(DEC), .WDOG_CYC(WD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .bus_addr(bus_addr), .bus_dir(bus_dir), .bus_wdata(bus_wdata),
        .bus_wdata_oe(bus_wdata_oe), .bus_req(bus_req), .bus_ack(sl_ack),
        .bus_rdata(sl_rdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int t_addr, t_req_rise, t_req_fall, t_ack_rise, t_ack_fall, t_rsp, n_rsp = 0;
    int sl_mode = 0;         // 0 normal, 1 never acknowledge, 2 acknowledge sticks high
    int ack_dly = 1;
    logic stuck_rel = 1'b0;
    logic [DW-1:0] mem [16];
    logic [DW-1:0] wr_seen;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog for the whole run
    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Monitor: time-stamp bus events, sampled away from the active edge
    logic p_req = 1'b0, p_rdy = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !p_req) t_req_rise = cyc;
            if (!bus_req && p_req) t_req_fall = cyc;
            if (!cmd_ready && p_rdy) t_addr = cyc;
            if (rsp_valid) begin t_rsp = cyc; n_rsp++; end
        end
        p_req = bus_req;
        p_rdy = cmd_ready;
    end

    // Behavioural slave: four-phase return-to-zero handshake
    always begin
        @(negedge clk);
        if (rst_n && bus_req && !sl_ack && sl_mode != 1) begin
            for (int i = 0; i < ack_dly; i++) @(negedge clk);
            if (bus_dir) begin mem[bus_addr[3:0]] = bus_wdata; wr_seen = bus_wdata; end
            else sl_rdata = mem[bus_addr[3:0]];
            sl_ack = 1'b1;
            t_ack_rise = cyc;
            while (bus_req) @(negedge clk);
            sl_rdata = 16'hDEAD;
            if (sl_mode == 2) begin
                while (!stuck_rel) @(negedge clk);
            end
            for (int i = 0; i < ack_dly; i++) @(negedge clk);
            if (sl_mode == 0 && bus_dir) begin
                // R7: drivers still on with unchanged data before acknowledge drops
                chk(bus_wdata_oe === 1'b1, "R7 oe before ack low", bus_wdata_oe, 1);
                chk(bus_wdata === wr_seen, "R7 wdata stable", bus_wdata, wr_seen);
            end
            sl_ack = 1'b0;
            t_ack_fall = cyc;
        end
    end

    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [DW-1:0] rd, output logic er);
        int guard;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(bus_addr === a && bus_dir === wr, "R2 bus fields", {bus_dir, bus_addr}, {wr, a});
        chk(bus_wdata_oe === wr, "R2 oe follows direction", bus_wdata_oe, wr);
        chk(cmd_ready === 1'b0, "R2 busy", cmd_ready, 0);
        guard = 0;
        while (!rsp_valid && guard < 1000) begin @(negedge clk); guard++; end
        rd = rsp_rdata; er = rsp_err;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R6 single pulse", rsp_valid, 0);
        chk(bus_wdata_oe === 1'b0 && bus_req === 1'b0, "R7 bus released",
            {bus_wdata_oe, bus_req}, 0);
    endtask

    // Stimulus table: {write, addr, wdata, expected read data}
    localparam int NV = 8;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'h03, 16'h1234, 16'h0000},
        {1'b0, 8'h03, 16'h0000, 16'h1234},
        {1'b0, 8'h05, 16'h0000, 16'hA005},
        {1'b1, 8'h0F, 16'hFFFF, 16'h0000},
        {1'b0, 8'h0F, 16'h0000, 16'hFFFF},
        {1'b1, 8'h00, 16'h0000, 16'h0000},
        {1'b0, 8'h00, 16'h0000, 16'h0000},
        {1'b0, 8'h03, 16'h0000, 16'h1234}
    };

    initial begin
        logic [DW-1:0] rd;
        logic er;
        int base;
        for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + DW'(i);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(bus_req === 1'b0 && bus_wdata_oe === 1'b0, "R1 reset outputs low",
            {bus_req, bus_wdata_oe}, 0);
        chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset ready", {cmd_ready, rsp_valid}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req === 1'b0 && cmd_ready === 1'b1, "R1 after release", {bus_req, cmd_ready}, 1);

        // Table walk: main function with varying slave delay
        for (int v = 0; v < NV; v++) begin
            ack_dly = v % 4;
            run_txn(VEC[v][40], VEC[v][39:32], VEC[v][31:16], rd, er);
            chk(t_req_rise - t_addr == DEC, "R3 decode delay", t_req_rise - t_addr, DEC);
            chk(t_req_fall - t_ack_rise == 3, "R4 sync latency", t_req_fall - t_ack_rise, 3);
            chk(t_rsp - t_ack_fall == 3, "R6 completion timing", t_rsp - t_ack_fall, 3);
            chk(er === 1'b0, "R11 no error", er, 0);
            if (!VEC[v][40])
                chk(rd === VEC[v][15:0], "R5 read data", rd, VEC[v][15:0]);
        end

        // R8: command while busy is ignored
        ack_dly = 3;
        base = n_rsp;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h07; cmd_wdata = 16'h5A5A;
        @(negedge clk);
        cmd_addr = 8'h09; cmd_wdata = 16'h0BAD;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(bus_addr === 8'h07 && bus_wdata === 16'h5A5A, "R8 busy command ignored",
                {bus_addr, bus_wdata}, {8'h07, 16'h5A5A});
        end
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(n_rsp - base == 1, "R8 one response", n_rsp - base, 1);
        chk(mem[9] === 16'hA009, "R8 no extra write", mem[9], 16'hA009);
        run_txn(1'b0, 8'h07, 16'h0, rd, er);
        chk(rd === 16'h5A5A, "R5 readback after busy test", rd, 16'h5A5A);

        // R9: slave never acknowledges
        sl_mode = 1;
        run_txn(1'b1, 8'h02, 16'hCAFE, rd, er);
        chk(er === 1'b1, "R9 error flagged", er, 1);
        chk(t_req_fall - t_req_rise == WD, "R9 request width", t_req_fall - t_req_rise, WD);
        chk(t_rsp == t_req_fall, "R9 response with release", t_rsp, t_req_fall);
        chk(mem[2] === 16'hA002, "R9 no write landed", mem[2], 16'hA002);

        // R10: acknowledge sticks high
        sl_mode = 2; ack_dly = 0;
        run_txn(1'b0, 8'h05, 16'h0, rd, er);
        chk(er === 1'b1, "R10 error flagged", er, 1);
        chk(t_rsp - t_req_fall == WD, "R10 release timeout", t_rsp - t_req_fall, WD);
        stuck_rel = 1'b1;
        while (sl_ack) @(negedge clk);
        repeat (4) @(negedge clk);
        sl_mode = 0; stuck_rel = 1'b0; ack_dly = 1;
        chk(cmd_ready === 1'b1, "R10 back to idle", cmd_ready, 1);
        run_txn(1'b0, 8'h0F, 16'h0, rd, er);
        chk(rd === 16'hFFFF && er === 1'b0, "R11 recovery read", {er, rd}, 17'h0FFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule